// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

The block is a first-in first-out buffer whose write side and read side run on independent clocks. Its depth is a power-of-two parameter from 256 to 8192 words. A word is accepted on a rising write-clock edge only when both active-low write enables are low. A word is delivered on a rising read-clock edge only when both active-low read enables are low. Either second enable may be tied low when it is not needed.

Besides exact full and empty indications, the block drives two active-low threshold flags. The almost-full flag is set by an offset `m` and is computed in the write domain. The almost-empty flag is set by an offset `n` and is computed in the read domain. Each side sees the other side's pointer through a Gray-coded copy and a two-flop synchronizer. A flag therefore follows activity on the opposite side only after a few of its own clock cycles. The flags err only toward caution: almost-full may stay low a little longer than the true level, and almost-empty may stay low a little longer than the true level.

Top module: `dualClkFifo`

## Requirements
- R1: A write takes place on a rising `wrClk` edge only when `wrEn1N` and `wrEn2N` are both 0. With either of them at 1 the word is not stored, so it is never read out.
- R2: A read takes place on a rising `rdClk` edge only when `rdEn1N` and `rdEn2N` are both 0. The word read is presented on `rdData` from that same edge onward. With either enable at 1, nothing is consumed.
- R3: `fullN` is 0 from the write edge that brings the level to DEPTH words. Writes attempted while `fullN` is 0 are discarded and the write pointer holds. Without a write, `fullN` cannot fall.
- R4: `emptyN` is 0 from the read edge that brings the level to zero. Reads attempted while `emptyN` is 0 are discarded, and `rdData` holds its last value. Without a read, `emptyN` cannot fall.
- R5: `almostFullN` is 0 when the level is DEPTH-`afOffset` words or more, and 1 when the level is below that.
- R6: `almostEmptyN` is 0 when the level is `aeOffset` words or fewer, and 1 when the level is above that.
- R7: Each write-clock edge loads `almostFullN` from the level held just before that edge. A write on the edge that drives the flag low therefore leaves one word more than the threshold. The next edge then reflects that write.
- R8: Each read-clock edge loads `almostEmptyN` from the level held just before that edge. The next edge then reflects a read made on the first edge.
- R9: Activity on the opposite side shows up in the write-side flags (`fullN`, `almostFullN`) only on `wrClk` edges. It shows up in the read-side flags (`emptyN`, `almostEmptyN`) only on `rdClk` edges. In both cases the flags settle within six cycles of their own clock once the other side is idle.
- R10: While `rstN` is 0 the buffer is emptied. `fullN` and `almostFullN` are 1, `emptyN` and `almostEmptyN` are 0, and `rdData` is 0.
- R11: Words are read out in exactly the order in which they were accepted, across full fill-and-drain cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both sides |
| wrEn1N | input | 1 | First write enable, active low |
| wrEn2N | input | 1 | Second write enable, active low |
| wrData | input | WIDTH | Word to store |
| rdEn1N | input | 1 | First read enable, active low |
| rdEn2N | input | 1 | Second read enable, active low |
| rdData | output | WIDTH | Last word read |
| afOffset | input | log2(DEPTH) | Almost-full offset m |
| aeOffset | input | log2(DEPTH) | Almost-empty offset n |
| fullN | output | 1 | Full flag, active low |
| emptyN | output | 1 | Empty flag, active low |
| almostFullN | output | 1 | Almost-full flag, active low, write domain |
| almostEmptyN | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The hardest thing to check from the ports is the one-edge lag of each almost flag. Synchronizer delay from the other side would normally blur it. The bench therefore keeps the opposite side idle until its pointer has settled. It then spaces every write or read with an idle edge of the same clock. The flag is sampled after the active edge, where it must show the level from before that edge, and again after the idle edge, where it must show the new level. Full fill-and-drain sweeps over every level are repeated for offset pairs at zero, one, mid-range and DEPTH-1. Between sweeps the bench waits a fixed number of cycles of the flag's own clock, so that the cross-domain settling can be checked.

// File: rtl/fifoPkg.sv
package fifoPkg;

  // Strobes issued by the control to the storage datapath.
  typedef struct packed {
    logic wrFire;  // store wrData at the write address this edge
    logic rdFire;  // fetch the word at the read address this edge
  } fifoStrobes_t;

endpackage

// File: rtl/graySync.sv
// Two-flop synchronizer for a Gray-coded pointer crossing into dstClk.
module graySync #(
  parameter int W = 9
) (
  input  logic         dstClk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] grayOut
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge dstClk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  assign grayOut = stage2;

endmodule

// File: rtl/fifoCtrl.sv
// Pointer, level and flag control for both clock domains.
module fifoCtrl #(
  parameter int DEPTH = 256
) (
  input  logic                       wrClk,
  input  logic                       rdClk,
  input  logic                       rstN,
  input  logic                       wrEn1N,
  input  logic                       wrEn2N,
  input  logic                       rdEn1N,
  input  logic                       rdEn2N,
  input  logic [$clog2(DEPTH)-1:0]   afOffset,
  input  logic [$clog2(DEPTH)-1:0]   aeOffset,
  output fifoPkg::fifoStrobes_t      strobes,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       fullN,
  output logic                       emptyN,
  output logic                       almostFullN,
  output logic                       almostEmptyN
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrPtr, wrPtrNext, wrGray;
  logic [PTR_W-1:0] rdGraySync, rdSyncBin;
  logic [PTR_W-1:0] wrLevelNow, wrLevelNext, afThresh;
  logic             wrFire;

  assign wrFire      = !wrEn1N && !wrEn2N && fullN;
  assign wrPtrNext   = wrPtr + PTR_W'(wrFire);
  assign rdSyncBin   = gray2bin(rdGraySync);
  assign wrLevelNow  = wrPtr - rdSyncBin;
  assign wrLevelNext = wrPtrNext - rdSyncBin;
  assign afThresh    = DEPTH_P - {1'b0, afOffset};

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      wrGray      <= '0;
      fullN       <= 1'b1;
      almostFullN <= 1'b1;
    end else begin
      wrPtr       <= wrPtrNext;
      wrGray      <= bin2gray(wrPtrNext);
      fullN       <= (wrLevelNext != DEPTH_P);
      almostFullN <= (wrLevelNow < afThresh);
    end
  end

  // ---------------- read domain ----------------
  logic [PTR_W-1:0] rdPtr, rdPtrNext, rdGray;
  logic [PTR_W-1:0] wrGraySync, wrSyncBin;
  logic [PTR_W-1:0] rdLevelNow;
  logic             rdFire;

  assign rdFire     = !rdEn1N && !rdEn2N && emptyN;
  assign rdPtrNext  = rdPtr + PTR_W'(rdFire);
  assign wrSyncBin  = gray2bin(wrGraySync);
  assign rdLevelNow = wrSyncBin - rdPtr;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr        <= '0;
      rdGray       <= '0;
      emptyN       <= 1'b0;
      almostEmptyN <= 1'b0;
    end else begin
      rdPtr        <= rdPtrNext;
      rdGray       <= bin2gray(rdPtrNext);
      emptyN       <= (rdPtrNext != wrSyncBin);
      almostEmptyN <= (rdLevelNow > {1'b0, aeOffset});
    end
  end

  // ---------------- crossings ----------------
  graySync #(.W(PTR_W)) wrToRd_i (
    .dstClk (rdClk),
    .rstN   (rstN),
    .grayIn (wrGray),
    .grayOut(wrGraySync)
  );

  graySync #(.W(PTR_W)) rdToWr_i (
    .dstClk (wrClk),
    .rstN   (rstN),
    .grayIn (rdGray),
    .grayOut(rdGraySync)
  );

  assign strobes.wrFire = wrFire;
  assign strobes.rdFire = rdFire;
  assign wrAddr = wrPtr[ADDR_W-1:0];
  assign rdAddr = rdPtr[ADDR_W-1:0];

endmodule

// File: rtl/fifoDatapath.sv
// Word storage with one write port and one registered read port.
module fifoDatapath #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  fifoPkg::fifoStrobes_t    strobes,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [WIDTH-1:0]         wrData,
  output logic [WIDTH-1:0]         rdData
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrFire) begin
      mem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.rdFire) begin
      rdData <= mem[rdAddr];
    end
  end

endmodule

// File: rtl/dualClkFifo.sv
// Top: thin wrapper joining control and storage.
module dualClkFifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  logic                     wrEn1N,
  input  logic                     wrEn2N,
  input  logic [WIDTH-1:0]         wrData,
  input  logic                     rdEn1N,
  input  logic                     rdEn2N,
  output logic [WIDTH-1:0]         rdData,
  input  logic [$clog2(DEPTH)-1:0] afOffset,
  input  logic [$clog2(DEPTH)-1:0] aeOffset,
  output logic                     fullN,
  output logic                     emptyN,
  output logic                     almostFullN,
  output logic                     almostEmptyN
);

  localparam int ADDR_W = $clog2(DEPTH);

  fifoPkg::fifoStrobes_t strobes;
  logic [ADDR_W-1:0]     wrAddr;
  logic [ADDR_W-1:0]     rdAddr;

  fifoCtrl #(.DEPTH(DEPTH)) ctrl_i (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .wrEn1N      (wrEn1N),
    .wrEn2N      (wrEn2N),
    .rdEn1N      (rdEn1N),
    .rdEn2N      (rdEn2N),
    .afOffset    (afOffset),
    .aeOffset    (aeOffset),
    .strobes     (strobes),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .fullN       (fullN),
    .emptyN      (emptyN),
    .almostFullN (almostFullN),
    .almostEmptyN(almostEmptyN)
  );

  fifoDatapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) data_i (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: rtl/dualClkFifoChk.sv
// Protocol checks attached to the top module.
module dualClkFifoChk (
  input logic wrClk,
  input logic rdClk,
  input logic rstN,
  input logic wrEn1N,
  input logic wrEn2N,
  input logic rdEn1N,
  input logic rdEn2N,
  input logic fullN,
  input logic emptyN,
  input logic wrFire,
  input logic rdFire
);

  assert_write_both_enables_R1: assert property (
    @(posedge wrClk) disable iff (!rstN) wrFire |-> (!wrEn1N && !wrEn2N));

  assert_read_both_enables_R2: assert property (
    @(posedge rdClk) disable iff (!rstN) rdFire |-> (!rdEn1N && !rdEn2N));

  assert_no_overflow_R3: assert property (
    @(posedge wrClk) disable iff (!rstN) !fullN |-> !wrFire);

  assert_full_needs_write_R3: assert property (
    @(posedge wrClk) disable iff (!rstN) (fullN && !wrFire) |=> fullN);

  assert_no_underflow_R4: assert property (
    @(posedge rdClk) disable iff (!rstN) !emptyN |-> !rdFire);

  assert_empty_needs_read_R4: assert property (
    @(posedge rdClk) disable iff (!rstN) (emptyN && !rdFire) |=> emptyN);

endmodule

bind dualClkFifo dualClkFifoChk chk_i (
  .wrClk (wrClk),
  .rdClk (rdClk),
  .rstN  (rstN),
  .wrEn1N(wrEn1N),
  .wrEn2N(wrEn2N),
  .rdEn1N(rdEn1N),
  .rdEn2N(rdEn2N),
  .fullN (fullN),
  .emptyN(emptyN),
  .wrFire(strobes.wrFire),
  .rdFire(strobes.rdFire)
);

// File: tb/dualClkFifo_tb_top.sv
module dualClkFifo_tb_top;

  localparam int DEPTH  = 256;
  localparam int WIDTH  = 16;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              wrClk = 1'b0;
  logic              rdClk = 1'b0;
  logic              rstN  = 1'b0;
  logic              wrEn1N = 1'b1, wrEn2N = 1'b1;
  logic              rdEn1N = 1'b1, rdEn2N = 1'b1;
  logic [WIDTH-1:0]  wrData = '0;
  logic [WIDTH-1:0]  rdData;
  logic [ADDR_W-1:0] afOffset = '0, aeOffset = '0;
  logic              fullN, emptyN, almostFullN, almostEmptyN;

  int checks = 0;
  int fails  = 0;
  int level  = 0;
  int wrSeq  = 0;
  int rdSeq  = 0;
  int mVal   = 0;
  int nVal   = 0;
  logic [WIDTH-1:0] lastRead = '0;

  always #5 wrClk = ~wrClk;
  always #7 rdClk = ~rdClk;

  dualClkFifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn1N(wrEn1N), .wrEn2N(wrEn2N), .wrData(wrData),
    .rdEn1N(rdEn1N), .rdEn2N(rdEn2N), .rdData(rdData),
    .afOffset(afOffset), .aeOffset(aeOffset),
    .fullN(fullN), .emptyN(emptyN),
    .almostFullN(almostFullN), .almostEmptyN(almostEmptyN)
  );

  function automatic logic [WIDTH-1:0] pattern(input int s);
    return WIDTH'((s * 40503 + 7) ^ (s >> 3));
  endfunction

  function automatic logic afExp(input int c);
    return c < (DEPTH - mVal);
  endfunction

  function automatic logic aeExp(input int c);
    return c > nVal;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (level=%0d m=%0d n=%0d)",
               req, act, exp, level, mVal, nVal);
    end
  endtask

  // Write attempt, followed by an idle write edge.
  task automatic doWrite(input logic both);
    int pre;
    logic accept;
    pre = level;
    accept = both && (level < DEPTH);
    @(negedge wrClk);
    wrData = pattern(wrSeq);
    wrEn1N = 1'b0;
    wrEn2N = both ? 1'b0 : 1'b1;
    @(posedge wrClk); #2;
    if (accept) begin
      level++;
      wrSeq++;
    end
    chk("R7 almostFullN on active edge", almostFullN, afExp(pre));
    chk("R3 fullN after write edge", fullN, level != DEPTH);
    @(negedge wrClk);
    wrEn1N = 1'b1;
    wrEn2N = 1'b1;
    @(posedge wrClk); #2;
    chk("R5 almostFullN after idle edge", almostFullN, afExp(level));
  endtask

  // Read attempt, followed by an idle read edge.
  task automatic doRead(input logic both);
    int pre;
    logic accept;
    pre = level;
    accept = both && (level > 0);
    @(negedge rdClk);
    rdEn1N = 1'b0;
    rdEn2N = both ? 1'b0 : 1'b1;
    @(posedge rdClk); #2;
    if (accept) begin
      lastRead = pattern(rdSeq);
      level--;
      rdSeq++;
    end
    chk("R11 rdData order", rdData, lastRead);
    chk("R8 almostEmptyN on active edge", almostEmptyN, aeExp(pre));
    chk("R4 emptyN after read edge", emptyN, level != 0);
    @(negedge rdClk);
    rdEn1N = 1'b1;
    rdEn2N = 1'b1;
    @(posedge rdClk); #2;
    chk("R6 almostEmptyN after idle edge", almostEmptyN, aeExp(level));
  endtask

  task automatic settleWr();
    repeat (6) @(posedge wrClk);
    #2;
  endtask

  task automatic settleRd();
    repeat (6) @(posedge rdClk);
    #2;
  endtask

  task automatic sweep(input int m, input int n);
    mVal = m;
    nVal = n;
    afOffset = ADDR_W'(m);
    aeOffset = ADDR_W'(n);
    settleWr();
    chk("R5 almostFullN when empty", almostFullN, afExp(0));
    settleRd();
    chk("R6 almostEmptyN when empty", almostEmptyN, aeExp(0));
    for (int i = 0; i < DEPTH; i++) begin
      doWrite(1'b1);
      if (i == DEPTH / 2) begin
        doWrite(1'b0);  // R1: one enable only, must be dropped
      end
    end
    for (int k = 0; k < 3; k++) begin
      doWrite(1'b1);    // R3: writes while full are discarded
    end
    settleRd();
    chk("R9 emptyN follows writes", emptyN, 1);
    chk("R9 almostEmptyN follows writes", almostEmptyN, aeExp(level));
    for (int i = 0; i < DEPTH; i++) begin
      doRead(1'b1);
      if (i == DEPTH / 3) begin
        doRead(1'b0);   // R2: one enable only, nothing consumed
      end
    end
    for (int k = 0; k < 2; k++) begin
      doRead(1'b1);     // R4: reads while empty are discarded
    end
    settleWr();
    chk("R9 fullN follows reads", fullN, 1);
    chk("R9 almostFullN follows reads", almostFullN, afExp(level));
  endtask

  initial begin
    #25;
    chk("R10 fullN in reset", fullN, 1);
    chk("R10 almostFullN in reset", almostFullN, 1);
    chk("R10 emptyN in reset", emptyN, 0);
    chk("R10 almostEmptyN in reset", almostEmptyN, 0);
    chk("R10 rdData in reset", rdData, 0);
    #8;
    rstN = 1'b1;
    sweep(0, 0);
    sweep(1, 1);
    sweep(3, 200);
    sweep(128, 17);
    sweep(DEPTH - 1, DEPTH - 1);
    chk("R11 word count read", rdSeq, wrSeq);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule